// File: doc/BRIEF.md
# Addressable RGB Pixel Waveform Serializer

This block turns a stream of 24-bit pixel words into the single-wire, self-clocked waveform that chained smart RGB LEDs expect. Every data bit becomes a high pulse followed by a low pulse. A one bit and a zero bit each have their own programmable high and low lengths, counted in module-clock cycles. The three colour bytes of a pixel can be sent in any of six orders, and each byte goes out most significant bit first.

A frame starts when the engine is enabled with a non-zero pixel count. The block pulls pixels one at a time through a valid/ready handshake. If no pixel is ready when one is needed, the line stays low and the block waits. After the last pixel it holds the line low for a programmable reset gap. It then raises a single-cycle completion pulse. If the enable is still high, the next frame starts on its own.

Top module: `pixel_wave_tx`

## Requirements
- R1: While rst_ni is low, line_o, done_o and pix_ready_o are all 0.
- R2: A frame starts only from idle, and only when en_i is 1 and frame_len_i is non-zero. With en_i at 0, or with a zero length, pix_ready_o stays 0 and no pixel is consumed.
- R3: A one bit drives line_o high for t1h_i cycles and then low for t1l_i cycles. A zero bit uses t0h_i and t0l_i the same way. A count of 0 behaves as 1. The timing inputs and gap_i are sampled when the frame starts.
- R4: The input word holds red in [23:16], green in [15:8] and blue in [7:0]. The colour-order codes are 0=RGB, 1=RBG, 2=GRB, 3=GBR, 4=BRG and 5=BGR; codes 6 and 7 behave as GRB. The order is sampled at frame start. Each byte is sent MSB first.
- R5: pix_ready_o is 1 only while the block waits for the next pixel, with line_o low. Each pixel is taken in exactly one cycle with pix_valid_i=1 and pix_ready_o=1, and its first high phase begins in the next cycle. While valid is absent, line_o stays low.
- R6: After the last bit of the frame, line_o stays low for gap_i cycles (0 behaves as 1). done_o is then 1 for exactly one cycle.
- R7: If en_i is still 1 after done_o, the next frame starts without further action, one idle cycle later.
- R8: The frame length is sampled at frame start. Any length above MAX_PIX (1024 by default) is clamped to MAX_PIX pixels.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Module clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| en_i | input | 1 | Engine enable |
| frame_len_i | input | LEN_W (13) | Pixels per frame |
| color_order_i | input | 3 | Colour-byte order code |
| t0h_i | input | T0H_W (5) | High cycles of a zero bit |
| t0l_i | input | T0L_W (6) | Low cycles of a zero bit |
| t1h_i | input | T1H_W (6) | High cycles of a one bit |
| t1l_i | input | T1L_W (5) | Low cycles of a one bit |
| gap_i | input | GAP_W (20) | Reset-gap cycles after a frame |
| pix_data_i | input | 24 | Pixel word, R/G/B |
| pix_valid_i | input | 1 | Pixel word valid |
| pix_ready_o | output | 1 | Pixel word accepted when valid |
| line_o | output | 1 | Serial LED data line |
| done_o | output | 1 | One-cycle frame-complete pulse |

## Verification
The bench feeds typical 50 MHz timings with a 15000-cycle gap. It then runs each of the eight order codes, all-zero counts, starved and throttled pixel supply, back-to-back frames and a 2000-pixel request that changes length mid-frame.

Each case targets a specific fault:
- A design that treats a zero count as a very long phase shows up in the all-zero run.
- A design that sends bytes LSB first or decodes codes 6 and 7 wrongly shifts high pulses by whole cycles.
- A design that raises the line before data arrives shows up under starved or throttled supply.
- A design that does not clamp the length, or re-reads it during a frame, consumes the wrong number of pixels.
- A design that fires done_o at the wrong time or more than once is caught, because the line and done_o are compared every cycle.

// File: rtl/pwt_pkg.sv
package pwt_pkg;

  localparam int PIX_W = 24;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FETCH,
    ST_HIGH,
    ST_LOW,
    ST_GAP,
    ST_DONE
  } pwt_state_e;

  // Source byte for a send slot: 0=red, 1=green, 2=blue. Slot 0 goes out first.
  function automatic logic [1:0] lane_src(input logic [2:0] code, input int slot);
    logic [5:0] map;
    case (code)
      3'd0: map = {2'd0, 2'd1, 2'd2};
      3'd1: map = {2'd0, 2'd2, 2'd1};
      3'd3: map = {2'd1, 2'd2, 2'd0};
      3'd4: map = {2'd2, 2'd0, 2'd1};
      3'd5: map = {2'd2, 2'd1, 2'd0};
      default: map = {2'd1, 2'd0, 2'd2};
    endcase
    case (slot)
      0: return map[5:4];
      1: return map[3:2];
      default: return map[1:0];
    endcase
  endfunction

endpackage

// File: rtl/pwt_reorder.sv
module pwt_reorder
  import pwt_pkg::*;
(
  input  logic [2:0]       order_i,
  input  logic [PIX_W-1:0] word_i,
  output logic [PIX_W-1:0] word_o
);

  localparam int NLANE = 3;

  logic [7:0] lane_byte [NLANE];

  for (genvar l = 0; l < NLANE; l++) begin : g_lane
    logic [1:0] src;
    assign src = lane_src(order_i, l);
    assign lane_byte[l] = (src == 2'd0) ? word_i[23:16] :
                          (src == 2'd1) ? word_i[15:8]  : word_i[7:0];
  end

  assign word_o = {lane_byte[0], lane_byte[1], lane_byte[2]};

endmodule

// File: rtl/pwt_phase_timer.sv
module pwt_phase_timer #(
  parameter int W = 20
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         run_i,
  input  logic [W-1:0] dur_i,
  output logic         last_o
);

  logic [W-1:0] cnt_q;
  logic [W-1:0] eff;

  // zero length acts as one cycle
  assign eff    = (dur_i == '0) ? W'(1) : dur_i;
  assign last_o = run_i && (cnt_q >= eff - W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (clr_i) cnt_q <= '0;
    else if (run_i) cnt_q <= cnt_q + W'(1);
  end

  p_cnt_bound_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i |-> (cnt_q < eff));

endmodule

// File: rtl/pwt_seq.sv
module pwt_seq
  import pwt_pkg::*;
#(
  parameter int LEN_W   = 13,
  parameter int MAX_PIX = 1024,
  parameter int T0H_W   = 5,
  parameter int T0L_W   = 6,
  parameter int T1H_W   = 6,
  parameter int T1L_W   = 5,
  parameter int GAP_W   = 20
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [LEN_W-1:0] frame_len_i,
  input  logic [2:0]       color_order_i,
  input  logic [T0H_W-1:0] t0h_i,
  input  logic [T0L_W-1:0] t0l_i,
  input  logic [T1H_W-1:0] t1h_i,
  input  logic [T1L_W-1:0] t1l_i,
  input  logic [GAP_W-1:0] gap_i,
  input  logic             pix_valid_i,
  input  logic [PIX_W-1:0] pix_word_i,
  output logic [2:0]       order_o,
  output logic             pix_ready_o,
  output logic             line_o,
  output logic             done_o,
  output logic             tmr_clr_o,
  output logic             tmr_run_o,
  output logic [GAP_W-1:0] tmr_dur_o,
  input  logic             tmr_last_i
);

  localparam int CNT_W = $clog2(MAX_PIX + 1);
  localparam int BIT_W = $clog2(PIX_W);
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(PIX_W - 1);

  pwt_state_e state_q, state_d;

  logic [PIX_W-1:0] sh_q;
  logic [BIT_W-1:0] bit_q;
  logic [CNT_W-1:0] pix_q, len_q, len_eff;
  logic [2:0]       order_q;
  logic [T0H_W-1:0] t0h_q;
  logic [T0L_W-1:0] t0l_q;
  logic [T1H_W-1:0] t1h_q;
  logic [T1L_W-1:0] t1l_q;
  logic [GAP_W-1:0] gap_q;

  logic start, bit_last, pix_last, cur_bit;

  assign len_eff  = (frame_len_i > LEN_W'(MAX_PIX)) ? CNT_W'(MAX_PIX) : CNT_W'(frame_len_i);
  assign start    = (state_q == ST_IDLE) && en_i && (frame_len_i != '0);
  assign bit_last = (bit_q == LAST_BIT);
  assign pix_last = ((pix_q + CNT_W'(1)) == len_q);
  assign cur_bit  = sh_q[PIX_W-1];

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE:  if (start) state_d = ST_FETCH;
      ST_FETCH: if (pix_valid_i) state_d = ST_HIGH;
      ST_HIGH:  if (tmr_last_i) state_d = ST_LOW;
      ST_LOW: begin
        if (tmr_last_i) begin
          if (!bit_last)     state_d = ST_HIGH;
          else if (pix_last) state_d = ST_GAP;
          else               state_d = ST_FETCH;
        end
      end
      ST_GAP:   if (tmr_last_i) state_d = ST_DONE;
      ST_DONE:  state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_comb begin
    case (state_q)
      ST_HIGH: tmr_dur_o = cur_bit ? GAP_W'(t1h_q) : GAP_W'(t0h_q);
      ST_LOW:  tmr_dur_o = cur_bit ? GAP_W'(t1l_q) : GAP_W'(t0l_q);
      ST_GAP:  tmr_dur_o = gap_q;
      default: tmr_dur_o = '0;
    endcase
  end

  assign tmr_clr_o = (state_d != state_q);
  assign tmr_run_o = (state_q == ST_HIGH) || (state_q == ST_LOW) || (state_q == ST_GAP);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      sh_q    <= '0;
      bit_q   <= '0;
      pix_q   <= '0;
      len_q   <= '0;
      order_q <= 3'd2;
      t0h_q   <= '0;
      t0l_q   <= '0;
      t1h_q   <= '0;
      t1l_q   <= '0;
      gap_q   <= '0;
    end else begin
      state_q <= state_d;
      if (start) begin
        len_q   <= len_eff;
        order_q <= color_order_i;
        t0h_q   <= t0h_i;
        t0l_q   <= t0l_i;
        t1h_q   <= t1h_i;
        t1l_q   <= t1l_i;
        gap_q   <= gap_i;
        pix_q   <= '0;
      end
      if (state_q == ST_FETCH && pix_valid_i) begin
        sh_q  <= pix_word_i;
        bit_q <= '0;
      end
      if (state_q == ST_LOW && tmr_last_i) begin
        if (!bit_last) begin
          sh_q  <= {sh_q[PIX_W-2:0], 1'b0};
          bit_q <= bit_q + BIT_W'(1);
        end else begin
          pix_q <= pix_q + CNT_W'(1);
        end
      end
    end
  end

  assign order_o     = order_q;
  assign pix_ready_o = (state_q == ST_FETCH);
  assign line_o      = (state_q == ST_HIGH);
  assign done_o      = (state_q == ST_DONE);

  p_idle_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE && !en_i) |=> !pix_ready_o);

  p_rise_src_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(line_o) |-> ($past(state_q) == ST_LOW || $past(pix_valid_i)));

  p_stall_low_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pix_ready_o && !pix_valid_i) |=> (pix_ready_o && !line_o));

  p_done_once_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> (!done_o && !pix_ready_o && !line_o));

  p_len_bound_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_HIGH || state_q == ST_LOW) |-> (pix_q < len_q && len_q <= CNT_W'(MAX_PIX)));

endmodule

// File: rtl/pixel_wave_tx.sv
module pixel_wave_tx
  import pwt_pkg::*;
#(
  parameter int LEN_W   = 13,
  parameter int MAX_PIX = 1024,
  parameter int T0H_W   = 5,
  parameter int T0L_W   = 6,
  parameter int T1H_W   = 6,
  parameter int T1L_W   = 5,
  parameter int GAP_W   = 20
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [LEN_W-1:0] frame_len_i,
  input  logic [2:0]       color_order_i,
  input  logic [T0H_W-1:0] t0h_i,
  input  logic [T0L_W-1:0] t0l_i,
  input  logic [T1H_W-1:0] t1h_i,
  input  logic [T1L_W-1:0] t1l_i,
  input  logic [GAP_W-1:0] gap_i,
  input  logic [23:0]      pix_data_i,
  input  logic             pix_valid_i,
  output logic             pix_ready_o,
  output logic             line_o,
  output logic             done_o
);

  logic [2:0]       order;
  logic [PIX_W-1:0] word;
  logic             tmr_clr, tmr_run, tmr_last;
  logic [GAP_W-1:0] tmr_dur;

  pwt_reorder u_reorder (
    .order_i (order),
    .word_i  (pix_data_i),
    .word_o  (word)
  );

  pwt_phase_timer #(.W(GAP_W)) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (tmr_clr),
    .run_i  (tmr_run),
    .dur_i  (tmr_dur),
    .last_o (tmr_last)
  );

  pwt_seq #(
    .LEN_W(LEN_W), .MAX_PIX(MAX_PIX), .T0H_W(T0H_W), .T0L_W(T0L_W),
    .T1H_W(T1H_W), .T1L_W(T1L_W), .GAP_W(GAP_W)
  ) u_seq (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .en_i          (en_i),
    .frame_len_i   (frame_len_i),
    .color_order_i (color_order_i),
    .t0h_i         (t0h_i),
    .t0l_i         (t0l_i),
    .t1h_i         (t1h_i),
    .t1l_i         (t1l_i),
    .gap_i         (gap_i),
    .pix_valid_i   (pix_valid_i),
    .pix_word_i    (word),
    .order_o       (order),
    .pix_ready_o   (pix_ready_o),
    .line_o        (line_o),
    .done_o        (done_o),
    .tmr_clr_o     (tmr_clr),
    .tmr_run_o     (tmr_run),
    .tmr_dur_o     (tmr_dur),
    .tmr_last_i    (tmr_last)
  );

  p_reset_quiet_r1: assert property (@(posedge clk_i)
    !rst_ni |-> (!line_o && !done_o && !pix_ready_o));

endmodule

// File: tb/pixel_wave_tx_tb_top.sv
`timescale 1ns/1ps
module pixel_wave_tx_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en = 1'b0;
  logic [12:0] frame_len = '0;
  logic [2:0]  order = 3'd2;
  logic [4:0]  t0h = '0;
  logic [5:0]  t0l = '0;
  logic [5:0]  t1h = '0;
  logic [4:0]  t1l = '0;
  logic [19:0] gap = '0;
  logic [23:0] pix_data = '0;
  logic        pix_valid = 1'b0;
  logic        pix_ready, line, done;

  always #10 clk = ~clk;

  pixel_wave_tx dut_i (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .frame_len_i(frame_len),
    .color_order_i(order), .t0h_i(t0h), .t0l_i(t0l), .t1h_i(t1h), .t1l_i(t1l),
    .gap_i(gap), .pix_data_i(pix_data), .pix_valid_i(pix_valid),
    .pix_ready_o(pix_ready), .line_o(line), .done_o(done)
  );

  int compared = 0;
  int mismatched = 0;
  int done_cnt = 0;
  int acc = 0;
  int exp_len = 1;
  int stall_div = 1;
  int cyc = 0;
  string cur_req = "R1";
  int exp_q[$];
  logic [23:0] data_q[$];

  function automatic int eff(input int v);
    return (v == 0) ? 1 : v;
  endfunction

  function automatic logic [23:0] ordered(input logic [2:0] code, input logic [23:0] d);
    logic [7:0] r, g, b;
    r = d[23:16]; g = d[15:8]; b = d[7:0];
    case (code)
      3'd0: return {r, g, b};
      3'd1: return {r, b, g};
      3'd3: return {g, b, r};
      3'd4: return {b, r, g};
      3'd5: return {b, g, r};
      default: return {g, r, b};
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int expv);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, expv, $time);
    end
  endtask

  task automatic push_model(input logic [23:0] d);
    logic [23:0] w;
    w = ordered(order, d);
    for (int i = 23; i >= 0; i--) begin
      int h, l;
      h = w[i] ? eff(int'(t1h)) : eff(int'(t0h));
      l = w[i] ? eff(int'(t1l)) : eff(int'(t0l));
      repeat (h) exp_q.push_back(1);
      repeat (l) exp_q.push_back(0);
    end
    acc++;
    if (acc == exp_len) begin
      acc = 0;
      repeat (eff(int'(gap))) exp_q.push_back(0);
      exp_q.push_back(2);
    end
  endtask

  // per-cycle reference comparison and pixel driver
  always @(negedge clk) begin
    cyc++;
    if (!rst_n) begin
      check(!line && !done && !pix_ready, "R1", {line, done, pix_ready}, 0);
      pix_valid <= 1'b0;
    end else begin
      int e;
      bit popped;
      logic nv;
      popped = exp_q.size() > 0;
      e = popped ? exp_q.pop_front() : 0;
      check(line == (e == 1), cur_req, line, e == 1);
      check(done == (e == 2), cur_req, done, e == 2);
      if (popped) check(!pix_ready, "R5", pix_ready, 0);
      if (done) done_cnt++;
      nv = (data_q.size() > 0) && (cyc % stall_div == 0);
      pix_valid = nv;
      pix_data  = nv ? data_q[0] : 24'h0;
      if (nv && pix_ready) begin
        push_model(data_q[0]);
        void'(data_q.pop_front());
      end
    end
  end

  task automatic set_timing(input int a, input int b, input int c, input int d, input int g);
    t0h = 5'(a); t0l = 6'(b); t1h = 6'(c); t1l = 5'(d); gap = 20'(g);
  endtask

  task automatic start_frame(input int len, input int ord, input bit keep_en);
    @(negedge clk);
    order = 3'(ord);
    frame_len = 13'(len);
    exp_len = (len > 1024) ? 1024 : len;
    en = 1'b1;
    @(negedge clk);
    while (!pix_ready) @(negedge clk);
    if (!keep_en) en = 1'b0;
  endtask

  task automatic wait_done(input int target);
    while (done_cnt < target) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic end_checks(input string req, input int frames);
    check(exp_q.size() == 0, req, exp_q.size(), 0);
    check(done_cnt == frames, req, done_cnt, frames);
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog expired actual=%0d expected=done", cyc);
    finish_run();
  end

  initial begin
    int frames;
    frames = 0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;

    // R3: typical timings at 50 MHz with a long gap
    cur_req = "R3";
    set_timing(16, 42, 44, 14, 15000);
    data_q.push_back(24'hA53CF0); data_q.push_back(24'h00FF01); data_q.push_back(24'h80807F);
    start_frame(3, 2, 0);
    frames++; wait_done(frames); end_checks("R3", frames);

    // R4: every order code, codes 6 and 7 act as GRB
    cur_req = "R4";
    set_timing(2, 3, 4, 1, 3);
    for (int o = 0; o < 8; o++) begin
      data_q.push_back(24'h12F0C3 ^ 24'(o * 24'h010101));
      start_frame(1, o, 0);
      frames++; wait_done(frames); end_checks("R4", frames);
    end

    // R3 / R6: zero counts behave as one cycle
    cur_req = "R6";
    set_timing(0, 0, 0, 0, 0);
    data_q.push_back(24'hFFFFFF); data_q.push_back(24'h5A0081);
    start_frame(2, 0, 0);
    frames++; wait_done(frames); end_checks("R6", frames);

    // R5: throttled supply
    cur_req = "R5";
    set_timing(1, 2, 2, 1, 4);
    stall_div = 3;
    for (int i = 0; i < 4; i++) data_q.push_back(24'(32'h3C1E0F * (i + 1)));
    start_frame(4, 4, 0);
    frames++; wait_done(frames); end_checks("R5", frames);
    stall_div = 1;

    // R5: starved supply, line held low while waiting
    start_frame(2, 3, 0);
    repeat (30) begin
      @(negedge clk);
      check(pix_ready && !line, "R5", {pix_ready, line}, 2);
    end
    data_q.push_back(24'h0F0F0F); data_q.push_back(24'hF00001);
    frames++; wait_done(frames); end_checks("R5", frames);

    // R2: disabled, then enabled with zero length
    cur_req = "R2";
    data_q.push_back(24'hABCDEF);
    repeat (20) begin
      @(negedge clk);
      check(!pix_ready, "R2", pix_ready, 0);
    end
    frame_len = '0; en = 1'b1;
    repeat (20) begin
      @(negedge clk);
      check(!pix_ready, "R2", pix_ready, 0);
    end
    check(data_q.size() == 1, "R2", data_q.size(), 1);
    en = 1'b0;
    data_q.delete();

    // R7: back-to-back frames with enable held
    cur_req = "R7";
    set_timing(3, 1, 1, 3, 2);
    for (int i = 0; i < 4; i++) data_q.push_back(24'(32'h9A7 * (i + 3)));
    start_frame(2, 5, 1);
    frames += 2;
    while (done_cnt < frames) @(negedge clk);
    en = 1'b0;
    repeat (3) @(negedge clk);
    end_checks("R7", frames);
    check(!pix_ready, "R7", pix_ready, 0);

    // R8: oversize length clamped, mid-frame length change ignored
    cur_req = "R8";
    set_timing(1, 1, 1, 1, 2);
    for (int i = 0; i < 1030; i++) data_q.push_back(24'(i * 24'h010203));
    start_frame(2000, 1, 0);
    frame_len = 13'd5;
    frames++; wait_done(frames); end_checks("R8", frames);
    check(data_q.size() == 6, "R8", data_q.size(), 6);
    data_q.delete();

    finish_run();
  end

endmodule